// File: doc/BRIEF.md
# Byte-Serial Interrupt Packet Receiver

This block turns interrupt packets that arrive one byte per clock into one parallel message. Each packet is eighteen bytes long. The first two bytes form a 16-bit header, most significant byte first. The other sixteen bytes form a 128-bit payload, also most significant byte first. From the header the receiver takes a 5-bit target field and a 5-bit source field. When the last byte has been taken in, it presents target, source and payload together and raises a done strobe for one cycle.

The input is a valid-qualified byte stream with no ready signal. The receiver takes a byte on every cycle that `in_valid` is high, so the sender never sees back-pressure. The sender must keep `in_valid` high for all eighteen beats of a packet. If `in_valid` drops part-way through, the receiver throws away the partial packet and treats the next valid byte as the first header byte. The output side is a plain strobe with no ready: the parallel fields hold their value until the next packet completes.

Top module: `irq_byte_rx`

## Requirements
- R1: A synchronous active-high `rst` returns the receiver to idle, so the next valid byte is header byte 1. The same reset clears `msg_done`, `msg_target`, `msg_source` and `msg_payload` to zero, and this applies even in the middle of a packet.
- R2: Eighteen consecutive cycles with `in_valid` high form one packet. `msg_done` is high for exactly the one cycle after the clock edge that captures beat 18, and it is low at every other time.
- R3: Beat 1 supplies header bits [15:8] and beat 2 supplies header bits [7:0]. `msg_target` equals header bits [12:8] and `msg_source` equals header bits [4:0].
- R4: Header bits [15:13] and [7:5] are reserved. Any value in them leaves `msg_target` and `msg_source` unchanged.
- R5: Beat 3 supplies `msg_payload[127:120]`. Each later beat supplies the next lower byte, and beat 18 supplies `msg_payload[7:0]`.
- R6: If `in_valid` is low on any cycle before beat 18, the partial packet is discarded. `msg_done` does not rise for it, and the next valid byte is taken as header byte 1.
- R7: `msg_target`, `msg_source` and `msg_payload` change only on the edge that captures beat 18 of a packet. They hold their value across idle cycles and across aborted packets.
- R8: Beat 1 of a new packet may arrive on the cycle right after beat 18 of the previous packet. Both packets are then delivered correctly, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_byte` carries a packet beat |
| in_byte | input | 8 | Serial packet byte |
| msg_done | output | 1 | One-cycle strobe: a complete packet is on the outputs |
| msg_target | output | 5 | Decoded interrupt target |
| msg_source | output | 5 | Decoded interrupt source |
| msg_payload | output | 128 | Reassembled payload |

## Verification
If the beat counter slips, the header and payload bytes land in the wrong slots. The error shows on the very next strobe as swapped target and source or as a rotated payload. It can also show as a strobe that comes one beat early or late, or as a strobe for an aborted packet. A counter that fails to return to idle on an abort corrupts the first complete packet after the gap. A header or payload stage that keeps old bytes shows up when a packet follows an aborted one or follows its predecessor with no gap. The directed cases therefore abort at the first and last possible beats, send packets back to back, and send reserved header bits set to one. Each result is checked on the exact cycle the strobe is due.

// File: rtl/irx_pkg.sv
package irx_pkg;
  // Header beat that carries a given header bit; header is sent MSB byte first
  function automatic int unsigned hdr_beat_of(int unsigned bit_idx, int unsigned hdr_w,
                                              int unsigned byte_w);
    return (hdr_w - 1 - bit_idx) / byte_w;
  endfunction

  // Position of a header bit inside the byte of its beat
  function automatic int unsigned hdr_pos_of(int unsigned bit_idx, int unsigned byte_w);
    return bit_idx % byte_w;
  endfunction
endpackage

// File: rtl/irx_framer.sv
module irx_framer #(
  parameter int unsigned TOTAL     = 18,
  parameter int unsigned HDR_BEATS = 2,
  parameter int unsigned CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic [CNT_W-1:0] cnt,
  output logic             hdr_beat,
  output logic             pay_beat,
  output logic             last_beat
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] HDR_N = CNT_W'(HDR_BEATS);

  // cnt = number of beats of the current packet already captured
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!in_valid) begin
      cnt <= '0;                       // abort or idle: restart framing
    end else if (cnt == LAST) begin
      cnt <= '0;                       // packet complete, next beat is header 1
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    hdr_beat  = in_valid && (cnt < HDR_N);
    last_beat = in_valid && (cnt == LAST);
    pay_beat  = in_valid && (cnt >= HDR_N) && (cnt != LAST);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (cnt == '0)); // R6
  AST_WRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> (cnt == '0)); // R8
endmodule

// File: rtl/irx_pay_shift.sv
module irx_pay_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PAY_W  = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pay_beat,
  input  logic [BYTE_W-1:0]        in_byte,
  output logic [PAY_W-BYTE_W-1:0]  pay_sr
);
  localparam int unsigned SR_W = PAY_W - BYTE_W;

  generate
    if (SR_W > BYTE_W) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) pay_sr <= '0;
        else if (pay_beat) pay_sr <= {pay_sr[SR_W-BYTE_W-1:0], in_byte};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pay_sr <= '0;
        else if (pay_beat) pay_sr <= in_byte;
      end
    end
  endgenerate

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pay_beat |=> $stable(pay_sr)); // R5
endmodule

// File: rtl/irx_fields_out.sv
module irx_fields_out
  import irx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HDR_W  = 16,
  parameter int unsigned PAY_W  = 128,
  parameter int unsigned TGT_LO = 8,
  parameter int unsigned TGT_W  = 5,
  parameter int unsigned SRC_LO = 0,
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned CNT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hdr_beat,
  input  logic                    last_beat,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [BYTE_W-1:0]       in_byte,
  input  logic [PAY_W-BYTE_W-1:0] pay_sr,
  output logic                    msg_done,
  output logic [TGT_W-1:0]        msg_target,
  output logic [SRC_W-1:0]        msg_source,
  output logic [PAY_W-1:0]        msg_payload
);
  logic [TGT_W-1:0] tgt_q;
  logic [SRC_W-1:0] src_q;

  // Only the header bits that belong to a field get a flop; reserved bits are dropped
  for (genvar t = 0; t < TGT_W; t++) begin : g_tgt
    localparam int unsigned BEAT = hdr_beat_of(TGT_LO + t, HDR_W, BYTE_W);
    localparam int unsigned POS  = hdr_pos_of(TGT_LO + t, BYTE_W);
    logic b_q;
    always_ff @(posedge clk) begin
      if (rst) b_q <= 1'b0;
      else if (hdr_beat && cnt == CNT_W'(BEAT)) b_q <= in_byte[POS];
    end
    assign tgt_q[t] = b_q;
  end

  for (genvar s = 0; s < SRC_W; s++) begin : g_src
    localparam int unsigned BEAT = hdr_beat_of(SRC_LO + s, HDR_W, BYTE_W);
    localparam int unsigned POS  = hdr_pos_of(SRC_LO + s, BYTE_W);
    logic b_q;
    always_ff @(posedge clk) begin
      if (rst) b_q <= 1'b0;
      else if (hdr_beat && cnt == CNT_W'(BEAT)) b_q <= in_byte[POS];
    end
    assign src_q[s] = b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_done    <= 1'b0;
      msg_target  <= '0;
      msg_source  <= '0;
      msg_payload <= '0;
    end else begin
      msg_done <= last_beat;
      if (last_beat) begin
        msg_target  <= tgt_q;
        msg_source  <= src_q;
        msg_payload <= {pay_sr, in_byte};
      end
    end
  end

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hdr_beat |=> ($stable(tgt_q) && $stable(src_q))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    msg_done |=> !msg_done); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> $past(last_beat)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !last_beat |=> ($stable(msg_payload) && $stable(msg_target) && $stable(msg_source))); // R7
endmodule

// File: rtl/irq_byte_rx.sv
module irq_byte_rx #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned HDR_BEATS = 2,
  parameter int unsigned PAY_BEATS = 16,
  parameter int unsigned TGT_LO    = 8,
  parameter int unsigned TGT_W     = 5,
  parameter int unsigned SRC_LO    = 0,
  parameter int unsigned SRC_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [BYTE_W-1:0]             in_byte,
  output logic                          msg_done,
  output logic [TGT_W-1:0]              msg_target,
  output logic [SRC_W-1:0]              msg_source,
  output logic [PAY_BEATS*BYTE_W-1:0]   msg_payload
);
  localparam int unsigned HDR_W = HDR_BEATS * BYTE_W;
  localparam int unsigned PAY_W = PAY_BEATS * BYTE_W;
  localparam int unsigned TOTAL = HDR_BEATS + PAY_BEATS;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0]        cnt;
  logic                    hdr_beat;
  logic                    pay_beat;
  logic                    last_beat;
  logic [PAY_W-BYTE_W-1:0] pay_sr;

  irx_framer #(
    .TOTAL(TOTAL), .HDR_BEATS(HDR_BEATS), .CNT_W(CNT_W)
  ) i_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cnt(cnt),
    .hdr_beat(hdr_beat), .pay_beat(pay_beat), .last_beat(last_beat)
  );

  irx_pay_shift #(
    .BYTE_W(BYTE_W), .PAY_W(PAY_W)
  ) i_pay (
    .clk(clk), .rst(rst), .pay_beat(pay_beat), .in_byte(in_byte), .pay_sr(pay_sr)
  );

  irx_fields_out #(
    .BYTE_W(BYTE_W), .HDR_W(HDR_W), .PAY_W(PAY_W), .TGT_LO(TGT_LO), .TGT_W(TGT_W),
    .SRC_LO(SRC_LO), .SRC_W(SRC_W), .CNT_W(CNT_W)
  ) i_out (
    .clk(clk), .rst(rst), .hdr_beat(hdr_beat), .last_beat(last_beat), .cnt(cnt),
    .in_byte(in_byte), .pay_sr(pay_sr), .msg_done(msg_done), .msg_target(msg_target),
    .msg_source(msg_source), .msg_payload(msg_payload)
  );

  AST_BEAT_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_beat, pay_beat, last_beat})); // R2
  AST_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> (msg_payload[BYTE_W-1:0] == $past(in_byte))); // R5
endmodule

// File: tb/test_irq_byte_rx.sv
`timescale 1ns/1ps
module test_irq_byte_rx;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = 8'h00;
  logic         msg_done;
  logic [4:0]   msg_target;
  logic [4:0]   msg_source;
  logic [127:0] msg_payload;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_byte_rx i_irq_byte_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .msg_done(msg_done), .msg_target(msg_target), .msg_source(msg_source),
    .msg_payload(msg_payload)
  );

  function automatic logic [127:0] mkpay(logic [7:0] seed);
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[127-8*k -: 8] = seed + 8'(k * 8'h13);
    return p;
  endfunction

  function automatic logic [7:0] byte_at(logic [15:0] h, logic [127:0] p, int i);
    if (i == 0) return h[15:8];
    if (i == 1) return h[7:0];
    return p[127-8*(i-2) -: 8];
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, logic d, logic [4:0] t, logic [4:0] s, logic [127:0] p);
    chk({tag, " done"}, 128'(msg_done), 128'(d));
    chk({tag, " target"}, 128'(msg_target), 128'(t));
    chk({tag, " source"}, 128'(msg_source), 128'(s));
    chk({tag, " payload"}, msg_payload, p);
  endtask

  task automatic beat(logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
  endtask

  task automatic gap();
    @(negedge clk); in_valid = 1'b0; in_byte = 8'h5A;
  endtask

  task automatic send(logic [15:0] h, logic [127:0] p, int n);
    for (int i = 0; i < n; i++) beat(byte_at(h, p, i));
  endtask

  // Full packet then one idle cycle: strobe due at this sample point
  task automatic send_full_check(string tag, logic [15:0] h, logic [127:0] p);
    send(h, p, 18);
    chk({tag, " no early done"}, 128'(msg_done), 128'(0));
    gap();
    chk_out(tag, 1'b1, h[12:8], h[4:0], p);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_out("R1 reset", 1'b0, 5'd0, 5'd0, 128'd0);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    logic [127:0] p = mkpay(8'h21);
    send_full_check("R2 R3 R5 basic", 16'h0A13, p);
    gap();
    chk_out("R2 R7 after pulse", 1'b0, 5'h0A, 5'h13, p);
  endtask

  task automatic t_reserved();
    logic [127:0] p = mkpay(8'h77);
    send_full_check("R4 reserved ones", 16'hEAF3, p);
    gap();
    send_full_check("R4 reserved all set", 16'hFFFF, mkpay(8'h03));
    gap();
    send_full_check("R4 fields zero", 16'hE0E0, mkpay(8'h90));
    gap();
  endtask

  task automatic t_abort();
    logic [127:0] p0 = mkpay(8'h40);
    logic [127:0] p1 = mkpay(8'hC1);
    send_full_check("R6 ref", 16'h1C05, p0);
    send(16'h0102, mkpay(8'hEE), 10);
    gap();
    chk_out("R6 R7 abort mid", 1'b0, 5'h1C, 5'h05, p0);
    send(16'h0304, mkpay(8'hDD), 17);
    gap();
    chk_out("R6 R7 abort at 17", 1'b0, 5'h1C, 5'h05, p0);
    gap();
    chk_out("R6 no late done", 1'b0, 5'h1C, 5'h05, p0);
    send(16'h0909, mkpay(8'hAB), 1);
    gap();
    send_full_check("R6 after aborts", 16'h1107, p1);
    gap();
  endtask

  task automatic t_b2b();
    logic [15:0]  ha = 16'h1E01;
    logic [15:0]  hb = 16'h0316;
    logic [127:0] pa = mkpay(8'h0F);
    logic [127:0] pb = mkpay(8'hF0);
    send(ha, pa, 18);
    beat(byte_at(hb, pb, 0));
    chk_out("R8 first strobe", 1'b1, ha[12:8], ha[4:0], pa);
    beat(byte_at(hb, pb, 1));
    chk_out("R8 strobe single", 1'b0, ha[12:8], ha[4:0], pa);
    for (int i = 2; i < 18; i++) beat(byte_at(hb, pb, i));
    gap();
    chk_out("R8 second packet", 1'b1, hb[12:8], hb[4:0], pb);
    repeat (20) gap();
    chk_out("R7 long hold", 1'b0, hb[12:8], hb[4:0], pb);
  endtask

  task automatic t_midreset();
    send(16'h1F1F, mkpay(8'h55), 6);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_out("R1 mid-packet reset", 1'b0, 5'd0, 5'd0, 128'd0);
    send_full_check("R1 after reset", 16'h0C1A, mkpay(8'h66));
    gap();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_reserved();
    t_abort();
    t_b2b();
    t_midreset();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule